// File: doc/BRIEF.md
# Power State Register Access Gate

This block sits on the path from a host register bus to the register file of a network controller. It holds a small power control register that selects the normal state or one of two low-power states. It drives a READY flag and one clock-enable line for each module. While READY is low it filters the bus. A read of the power control register is still answered. A write to a designated test address is taken as a wake-up request. Every other access is stopped before it reaches the register file.

A host enters a low-power state by writing the state field. It later writes the test address to come back to the normal state. After the wake-up write, all clock enables return at once. READY rises after a programmable number of clocks. The register file keeps its contents throughout, because only clock enables are removed. When an access is blocked, its read data is zero, any write is discarded, and a one-clock violation flag is raised.

Top module: `pwr_access_gate`

## Requirements
- R1: Reset leaves the block in the normal state (code 00) with `ready` high and every bit of `clk_en` high.
- R2: While `ready` is high, writing code 01 or 10 into bits 1:0 of the power control register (`PWR_ADDR`) moves the block to that low-power state at the next clock, and `ready` is low from that clock on.
- R3: While `ready` is high, any access to an address other than `PWR_ADDR` is passed to the register file (`rf_req` high) in the same cycle, and read data comes back unchanged on `h_rdata`.
- R4: While `ready` is low, reads of `PWR_ADDR` are the only access that is served. Every other access is not forwarded, and a blocked read returns zero.
- R5: In the normal state all `clk_en` bits are high. In code 01 only bit `RX_IDX` is high. In code 10 all bits are low.
- R6: A blocked access sets `viol` high for exactly the one clock that follows it.
- R7: A write to `TEST_ADDR` while `ready` is low is a wake-up. It raises no violation and is not forwarded. It restores the normal state with all `clk_en` bits high at the next clock. `ready` rises `WAKE_DLY` clocks after the wake-up edge.
- R8: Writing code 11 into the state field leaves both the state and `ready` unchanged.
- R9: A read of `PWR_ADDR` returns the state code in bits 1:0, `ready` in bit 2, and zero in all other bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| h_req | input | 1 | Host access strobe, one cycle per access |
| h_we | input | 1 | Host write (1) or read (0) |
| h_addr | input | ADDR_W | Host register address |
| h_wdata | input | DATA_W | Host write data |
| h_rdata | output | DATA_W | Read data returned to the host |
| rf_req | output | 1 | Access forwarded to the register file |
| rf_we | output | 1 | Write flag toward the register file |
| rf_addr | output | ADDR_W | Address toward the register file |
| rf_wdata | output | DATA_W | Write data toward the register file |
| rf_rdata | input | DATA_W | Read data from the register file |
| ready | output | 1 | Device accessible |
| clk_en | output | NUM_CLK | Per-module clock enables |
| viol | output | 1 | One-clock flag for a blocked access |

## Verification
The filter is exercised with reads and writes to ordinary addresses while awake. This separates forwarding from local handling of the power register. The same reads and writes are then issued while asleep, together with a write to the power register itself, which shows the asymmetry between allowed reads and forbidden writes. Wake-up writes are issued from both low-power states, followed by accesses inside the READY delay. This tells the immediate return of the clock enables apart from the delayed rise of READY. A reserved state code checks that an unknown state is never entered.

// File: rtl/pwr_access_gate.sv
module pwr_access_gate #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int NUM_CLK = 4,
  parameter int RX_IDX = 1,
  parameter int WAKE_DLY = 16,
  parameter logic [ADDR_W-1:0] PWR_ADDR = 'h54,
  parameter logic [ADDR_W-1:0] TEST_ADDR = 'h64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              h_req,
  input  logic              h_we,
  input  logic [ADDR_W-1:0] h_addr,
  input  logic [DATA_W-1:0] h_wdata,
  output logic [DATA_W-1:0] h_rdata,
  output logic              rf_req,
  output logic              rf_we,
  output logic [ADDR_W-1:0] rf_addr,
  output logic [DATA_W-1:0] rf_wdata,
  input  logic [DATA_W-1:0] rf_rdata,
  output logic              ready,
  output logic [NUM_CLK-1:0] clk_en,
  output logic              viol
);

  localparam int CNT_W = $clog2(WAKE_DLY + 1);
  localparam logic [NUM_CLK-1:0] RX_MASK = NUM_CLK'(1) << RX_IDX;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  typedef enum logic [1:0] {PS_D0 = 2'b00, PS_D1 = 2'b01, PS_D2 = 2'b10} pstate_t;

  pstate_t          pstate;
  logic             rdy_q;
  logic [CNT_W-1:0] wcnt;

  wire hit_pwr  = h_addr == PWR_ADDR;
  wire hit_test = h_addr == TEST_ADDR;
  wire pwr_rd   = h_req & ~h_we & hit_pwr;
  wire pwr_wr   = h_req & h_we & hit_pwr & rdy_q;
  wire wake     = h_req & h_we & hit_test & ~rdy_q;
  wire blocked  = h_req & ~rdy_q & ~pwr_rd & ~wake;
  wire new_ok   = h_wdata[1:0] != 2'b11;

  assign rf_req   = h_req & rdy_q & ~hit_pwr;
  assign rf_we    = h_we;
  assign rf_addr  = h_addr;
  assign rf_wdata = h_wdata;
  assign ready    = rdy_q;

  assign h_rdata = pwr_rd ? {{(DATA_W-3){1'b0}}, rdy_q, pstate}
                 : (rf_req & ~h_we) ? rf_rdata : '0;

  always_comb begin
    case (pstate)
      PS_D0:   clk_en = '1;
      PS_D1:   clk_en = RX_MASK;
      default: clk_en = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pstate <= PS_D0;
      rdy_q  <= 1'b1;
      wcnt   <= '0;
      viol   <= 1'b0;
    end else begin
      viol <= blocked;
      if (wake) begin
        pstate <= PS_D0;
        wcnt   <= CNT_W'(WAKE_DLY);
      end else begin
        if (wcnt != '0) begin
          wcnt <= wcnt - CNT_ONE;
          if (wcnt == CNT_ONE) rdy_q <= 1'b1;
        end
        if (pwr_wr && new_ok) begin
          pstate <= pstate_t'(h_wdata[1:0]);
          rdy_q  <= h_wdata[1:0] == PS_D0;
        end
      end
    end
  end

  AST_LOWPWR_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (pstate != PS_D0) |-> !ready); // R2
  AST_NO_FWD_ASLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> !rf_req); // R4
  AST_BLOCKED_RD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (h_req && !h_we && !ready && !hit_pwr) |-> (h_rdata == '0)); // R4
  AST_VIOL_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    viol |-> $past(h_req)); // R6
  AST_WAKE_ALL_ON: assert property (@(posedge clk) disable iff (!rst_n)
    wake |=> (clk_en == '1)); // R7
  AST_READY_AFTER_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> ($past(wcnt) == CNT_ONE)); // R7

endmodule

// File: tb/sim_pwr_access_gate.sv
`timescale 1ns/1ps
module sim_pwr_access_gate;
  localparam logic [7:0] PWR = 8'h54;
  localparam logic [7:0] TST = 8'h64;
  localparam int WD = 5;
  localparam int RX = 1;

  logic clk = 0, rst_n = 0;
  logic h_req = 0, h_we = 0;
  logic [7:0] h_addr = 0;
  logic [15:0] h_wdata = 0;
  logic [15:0] h_rdata, rf_wdata, rf_rdata;
  logic rf_req, rf_we, ready, viol;
  logic [7:0] rf_addr;
  logic [3:0] clk_en;
  int n_run = 0, n_fail = 0;

  always #2 clk = ~clk;
  assign rf_rdata = 16'hC000 | {8'h00, rf_addr};

  pwr_access_gate #(.ADDR_W(8), .DATA_W(16), .NUM_CLK(4), .RX_IDX(RX),
    .WAKE_DLY(WD), .PWR_ADDR(PWR), .TEST_ADDR(TST)) u0 (
    .clk(clk), .rst_n(rst_n), .h_req(h_req), .h_we(h_we), .h_addr(h_addr),
    .h_wdata(h_wdata), .h_rdata(h_rdata), .rf_req(rf_req), .rf_we(rf_we),
    .rf_addr(rf_addr), .rf_wdata(rf_wdata), .rf_rdata(rf_rdata),
    .ready(ready), .clk_en(clk_en), .viol(viol));

  typedef struct {
    logic [15:0] rdata; logic fwd; logic viol; logic rdy; logic [3:0] ce; string tag;
  } item_t;
  item_t q[$];

  logic [1:0] m_state = 0;
  logic m_rdy = 1, m_pend = 0;
  int m_cnt = 0;

  task automatic chk(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  task automatic step(input logic req, input logic we, input logic [7:0] addr,
                      input logic [15:0] wd, input string tag);
    item_t it;
    logic wake, pwr_rd, fwd;
    @(posedge clk); #1;
    h_req = req; h_we = we; h_addr = addr; h_wdata = wd;
    pwr_rd = req && !we && addr == PWR;
    wake = req && we && addr == TST && !m_rdy;
    fwd = req && m_rdy && addr != PWR;
    it.tag = tag;
    it.fwd = fwd;
    it.rdata = pwr_rd ? {13'd0, m_rdy, m_state} : (fwd && !we) ? (16'hC000 | {8'h00, addr}) : 16'h0;
    it.viol = m_pend;
    it.rdy = m_rdy;
    it.ce = (m_state == 0) ? 4'hF : (m_state == 1) ? (4'b0001 << RX) : 4'h0;
    q.push_back(it);
    m_pend = req && !m_rdy && !pwr_rd && !wake;
    if (wake) begin
      m_state = 0; m_cnt = WD;
    end else begin
      if (m_cnt > 0) begin
        m_cnt--;
        if (m_cnt == 0) m_rdy = 1;
      end
      if (req && we && addr == PWR && m_rdy && wd[1:0] != 2'b11) begin
        m_state = wd[1:0];
        m_rdy = (wd[1:0] == 2'b00);
      end
    end
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(0, 0, 8'h00, 16'h0, tag);
  endtask

  initial begin
    item_t it;
    wait (rst_n);
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        it = q.pop_front();
        chk(it.tag, "rdata", h_rdata, it.rdata);
        chk(it.tag, "rf_req", {15'd0, rf_req}, {15'd0, it.fwd});
        chk(it.tag, "viol", {15'd0, viol}, {15'd0, it.viol});
        chk(it.tag, "ready", {15'd0, ready}, {15'd0, it.rdy});
        chk(it.tag, "clk_en", {12'd0, clk_en}, {12'd0, it.ce});
      end
    end
  end

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    idle(1, "R1 reset state");
    step(1, 0, PWR, 0, "R1 R9 reset read of power register");
    step(1, 0, 8'h10, 0, "R3 forwarded read");
    step(1, 1, 8'h10, 16'h1234, "R3 forwarded write");
    step(1, 1, PWR, 16'h0001, "R2 enter low-power code 01");
    step(1, 0, PWR, 0, "R2 R5 R9 read in code 01");
    step(1, 0, 8'h10, 0, "R4 blocked read");
    step(1, 1, 8'h20, 16'hBEEF, "R4 R6 blocked write");
    idle(2, "R6 violation single pulse");
    step(1, 1, TST, 16'h0, "R7 wake-up write");
    step(1, 0, 8'h10, 0, "R7 access during ready delay");
    idle(WD, "R7 waiting for ready");
    step(1, 0, PWR, 0, "R7 R9 awake read");
    step(1, 1, PWR, 16'h0002, "R5 enter low-power code 10");
    step(1, 0, PWR, 0, "R5 R9 read in code 10");
    step(1, 1, PWR, 16'h0000, "R4 R6 power write while asleep");
    step(1, 0, 8'h30, 0, "R4 R6 blocked read back-to-back");
    step(1, 1, TST, 16'h0, "R7 wake from code 10");
    idle(WD + 1, "R7 second wake delay");
    step(1, 1, PWR, 16'h0003, "R8 reserved code");
    step(1, 0, PWR, 0, "R8 R9 state after reserved code");
    step(1, 0, 8'h44, 0, "R3 forwarded read after wake");
    idle(3, "R6 trailing idle");
    @(posedge clk); @(posedge clk);
    summary();
  end
endmodule